// File: doc/BRIEF.md
# Double-Word Normalize Unit

This unit left-justifies a signed double word held as a pair of 16-bit halves. The upper half (A) carries the sign in its top bit and the upper 15 magnitude bits. The lower half (B) carries 15 more magnitude bits in bits 14..0, and its bit 15 is a spare bit outside the number. A normalize operation shifts the 30-bit magnitude left, one position per clock, until the magnitude bit just below A's sign no longer matches the sign, or until 32 shifts have been done. The number of shifts is kept in a 6-bit count register.

The same unit serves two readout operations that put a new value into the A result. The first returns the count alone. The second packs the carry flag, the double-precision mode flag and the memory parity error flag above the count. The caller pulses `start_i` with an operation code and waits for the one-cycle `done_o`. While a normalize is in progress, `busy_o` is high and any further starts are dropped.

Top module: `dword_normalizer`

## Requirements
- R1: After reset, `a_o`, `b_o` and `count_o` are zero and both `busy_o` and `done_o` are low.
- R2: Normalize (op 2'b00) loads A from `a_i`, B from `b_i` and clears the count. It then shifts only while A bit 15 equals A bit 14. An input already in normal form ends with a count of 0 and A and B unchanged.
- R3: In each shift, A bit 15 keeps its value, A bits 13..0 move up into bits 14..1, and B bit 14 enters A bit 0.
- R4: In each shift, B bits 13..0 move up into bits 14..1, a zero enters B bit 0, and B bit 15 keeps its value.
- R5: A normalize stops after 32 shifts even if the condition still holds, so an all-zero magnitude with sign 0 ends with a count of 32.
- R6: A normalize does one shift per clock and holds `busy_o` high throughout. `done_o` is high for exactly one cycle, at the cycle after the final test, which is count+2 rising edges after the edge that samples `start_i`. `done_o` is never high together with `busy_o`.
- R7: Count readout (op 2'b01) sets `a_o` to the count in bits 5..0, with bits 15..6 zero. `done_o` is high after one rising edge, and `b_o` and `count_o` are unchanged.
- R8: Status readout (op 2'b10 or 2'b11) sets `a_o` bit 15 to `carry_i`, bit 14 to `dpmode_i`, bit 13 to `parerr_i`, bits 12..6 to zero and bits 5..0 to the count. `done_o` is high after one rising edge, and `b_o` and `count_o` are unchanged.
- R9: A `start_i` seen while `busy_o` is high has no effect on the running normalize or on its result.
- R10: The count is 6 bits wide. It keeps its value across readouts and is cleared only when a new normalize begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins the operation selected by `op_i` when the unit is idle |
| op_i | input | 2 | 00 normalize, 01 count readout, 1x status readout |
| a_i | input | 16 | Upper half (A) operand loaded by normalize |
| b_i | input | 16 | Lower half (B) operand loaded by normalize |
| carry_i | input | 1 | Carry flag packed by the status readout |
| dpmode_i | input | 1 | Double-precision mode flag packed by the status readout |
| parerr_i | input | 1 | Memory parity error flag packed by the status readout |
| busy_o | output | 1 | High while a normalize is shifting |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 16 | A result |
| b_o | output | 16 | B result |
| count_o | output | 6 | Shift count register |

## Verification
The hardest cases to reach are the ones where the stop test depends on bits that came from B, and the case where the 32-shift cap ends the run instead of the sign test. Stimulus reaches these by choosing operands whose magnitude lies wholly in B or is all zeros or all ones, so a run takes 15, 29, 30 or 32 shifts. Runs that end through a sign mismatch in B's upper bits also test that B bit 15 stays put. A start pulsed mid-run during the longest, all-zero run checks that the result and the latency are unchanged.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

    typedef enum logic [1:0] {
        OP_NORM     = 2'b00,
        OP_COUNT    = 2'b01,
        OP_STAT     = 2'b10,
        OP_STAT_ALT = 2'b11
    } nrm_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } nrm_state_e;

endpackage

// File: rtl/nrm_step.sv
// One left shift of the split double word, plus the stop test on A.
module nrm_step #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] a_cur,
    input  logic [WORD_W-1:0] b_cur,
    output logic [WORD_W-1:0] a_nxt,
    output logic [WORD_W-1:0] b_nxt,
    output logic              aligned
);
    localparam int SGN = WORD_W - 1;
    localparam int TOP = WORD_W - 2;

    always_comb begin
        // A: sign kept, magnitude up by one, B's top magnitude bit fills in.
        a_nxt = {a_cur[SGN], a_cur[TOP-1:0], b_cur[TOP]};
        // B: spare top bit kept, magnitude up by one, zero fills in.
        b_nxt = {b_cur[SGN], b_cur[TOP-1:0], 1'b0};
        aligned = (a_cur[SGN] != a_cur[TOP]);
    end
endmodule

// File: rtl/nrm_readout.sv
// Builds the word returned by the count and status readouts.
module nrm_readout #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic [CNT_W-1:0]  count,
    input  logic              sel_status,
    input  logic              carry,
    input  logic              dpmode,
    input  logic              parerr,
    output logic [WORD_W-1:0] word
);
    localparam int FLAG_C = WORD_W - 1;
    localparam int FLAG_D = WORD_W - 2;
    localparam int FLAG_P = WORD_W - 3;

    always_comb begin
        word = '0;
        word[CNT_W-1:0] = count;
        if (sel_status) begin
            word[FLAG_C] = carry;
            word[FLAG_D] = dpmode;
            word[FLAG_P] = parerr;
        end
    end
endmodule

// File: rtl/dword_normalizer.sv
module dword_normalizer #(
    parameter int WORD_W      = 16,
    parameter int CNT_W       = 6,
    parameter int SHIFT_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              carry_i,
    input  logic              dpmode_i,
    input  logic              parerr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] a_o,
    output logic [WORD_W-1:0] b_o,
    output logic [CNT_W-1:0]  count_o
);
    import nrm_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(SHIFT_LIMIT);
    localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);

    typedef struct packed {
        nrm_state_e        st;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] a_step_d, b_step_d;
    logic              aligned_d;
    logic [WORD_W-1:0] rd_word_d;
    nrm_op_e           op_d;

    assign op_d = nrm_op_e'(op_i);

    nrm_step #(.WORD_W(WORD_W)) u_step (
        .a_cur   (r_q.a),
        .b_cur   (r_q.b),
        .a_nxt   (a_step_d),
        .b_nxt   (b_step_d),
        .aligned (aligned_d)
    );

    nrm_readout #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rd (
        .count      (r_q.cnt),
        .sel_status (op_i[1]),
        .carry      (carry_i),
        .dpmode     (dpmode_i),
        .parerr     (parerr_i),
        .word       (rd_word_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_d == OP_NORM) begin
                        r_d.a   = a_i;
                        r_d.b   = b_i;
                        r_d.cnt = '0;
                        r_d.st  = ST_SHIFT;
                    end else begin
                        r_d.a    = rd_word_d;
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (aligned_d || (r_q.cnt == LIMIT_CNT)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.a   = a_step_d;
                    r_d.b   = b_step_d;
                    r_d.cnt = r_q.cnt + ONE_CNT;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, a: '0, b: '0, cnt: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.st == ST_SHIFT);
    assign done_o  = r_q.done;
    assign a_o     = r_q.a;
    assign b_o     = r_q.b;
    assign count_o = r_q.cnt;

endmodule

// File: rtl/dword_normalizer_chk.sv
module dword_normalizer_chk #(
    parameter int WORD_W      = 16,
    parameter int CNT_W       = 6,
    parameter int SHIFT_LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] a_o,
    input logic [WORD_W-1:0] b_o,
    input logic [CNT_W-1:0]  count_o
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(SHIFT_LIMIT);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LIM);

    assert_a_sign_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (a_o[WORD_W-1] == $past(a_o[WORD_W-1])));

    assert_b_spare_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (b_o[WORD_W-1] == $past(b_o[WORD_W-1])));

    assert_one_shift_per_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

    assert_exit_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_readout_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i != 2'b00)) |=> (done_o && !busy_o));

    assert_readout_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i != 2'b00)) |=> $stable(count_o));

    assert_norm_clears_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 2'b00)) |=> (busy_o && (count_o == '0)));

endmodule

bind dword_normalizer dword_normalizer_chk #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .SHIFT_LIMIT(SHIFT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .busy_o(busy_o), .done_o(done_o), .a_o(a_o), .b_o(b_o), .count_o(count_o)
);

// File: tb/dword_normalizer_tb.sv
`timescale 1ns/1ps
module dword_normalizer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        carry_i = 1'b0;
    logic        dpmode_i = 1'b0;
    logic        parerr_i = 1'b0;
    logic        busy_o, done_o;
    logic [15:0] a_o, b_o;
    logic [5:0]  count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dword_normalizer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .dpmode_i(dpmode_i),
        .parerr_i(parerr_i), .busy_o(busy_o), .done_o(done_o),
        .a_o(a_o), .b_o(b_o), .count_o(count_o)
    );

    // {a_in, b_in, exp_a, exp_b, exp_count}
    localparam int NVEC = 12;
    localparam logic [71:0] VEC [NVEC] = '{
        {16'h4000, 16'h1234, 16'h4000, 16'h1234, 8'd0},
        {16'h2000, 16'h0000, 16'h4000, 16'h0000, 8'd1},
        {16'h0001, 16'h0000, 16'h4000, 16'h0000, 8'd14},
        {16'h0000, 16'h4000, 16'h4000, 16'h0000, 8'd15},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd32},
        {16'hFFFF, 16'h0000, 16'h8000, 16'h0000, 8'd15},
        {16'h8000, 16'h8001, 16'h8000, 16'h8001, 8'd0},
        {16'hC000, 16'h2000, 16'h8000, 16'h4000, 8'd1},
        {16'h0000, 16'h8001, 16'h4000, 16'h8000, 8'd29},
        {16'hFFFF, 16'h7FFF, 16'h8000, 16'h0000, 8'd30},
        {16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 8'd30},
        {16'h1234, 16'h5678, 16'h48D2, 16'h59E0, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Returns rising edges from the start-sampling edge to visible done.
    task automatic wait_done(input int first, output int lat);
        lat = first;
        while (!done_o) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic readout(input logic [1:0] op, input logic c, input logic d, input logic p,
                           input logic [15:0] exp_a, input logic [15:0] exp_b,
                           input logic [5:0] exp_cnt, input string req);
        carry_i = c; dpmode_i = d; parerr_i = p;
        launch(op, 16'hDEAD, 16'hBEEF);
        check({req, " done after one edge"}, {31'd0, done_o}, 32'd1);
        check({req, " a_o"}, {16'd0, a_o}, {16'd0, exp_a});
        check({req, " b_o unchanged"}, {16'd0, b_o}, {16'd0, exp_b});
        check("R10 count kept by readout", {26'd0, count_o}, {26'd0, exp_cnt});
        @(negedge clk);
        check({req, " done one cycle"}, {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 a_o", {16'd0, a_o}, 32'd0);
        check("R1 b_o", {16'd0, b_o}, 32'd0);
        check("R1 count_o", {26'd0, count_o}, 32'd0);
        check("R1 busy/done", {30'd0, busy_o, done_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] ea, eb;
            logic [7:0]  ec;
            ea = VEC[i][39:24];
            eb = VEC[i][23:8];
            ec = VEC[i][7:0];
            launch(2'b00, VEC[i][71:56], VEC[i][55:40]);
            check("R6 busy during run", {31'd0, busy_o}, {31'd0, (ec != 0) || !done_o});
            wait_done(1, lat);
            check("R3 A result", {16'd0, a_o}, {16'd0, ea});
            check("R4 B result", {16'd0, b_o}, {16'd0, eb});
            check((ec == 8'd32) ? "R5 capped count" : "R2 shift count",
                  {26'd0, count_o}, {24'd0, ec});
            check("R6 latency", lat, 32'(ec) + 32'd2);
            @(negedge clk);
            check("R6 done single cycle", {30'd0, busy_o, done_o}, 32'd0);
        end

        // Last run left count 2, A=48D2, B=59E0.
        readout(2'b01, 1'b1, 1'b1, 1'b1, 16'h0002, 16'h59E0, 6'd2, "R7 count readout");

        // Count 29 run, then status readouts.
        launch(2'b00, 16'h0000, 16'h8001);
        wait_done(1, lat);
        readout(2'b10, 1'b1, 1'b0, 1'b1, 16'hA01D, 16'h8000, 6'd29, "R8 status C,P");
        readout(2'b11, 1'b0, 1'b1, 1'b0, 16'h401D, 16'h8000, 6'd29, "R8 status D alt code");

        // R9: starts during a 32-shift run are dropped.
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b00; a_i = 16'h0000; b_i = 16'h0000;
        @(negedge clk);
        a_i = 16'h4000; b_i = 16'h1111;
        @(negedge clk);
        op_i = 2'b01;
        @(negedge clk);
        op_i = 2'b10;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(4, lat);
        check("R9 A unaffected", {16'd0, a_o}, 32'd0);
        check("R9 B unaffected", {16'd0, b_o}, 32'd0);
        check("R9 count unaffected", {26'd0, count_o}, 32'd32);
        check("R9 latency unaffected", lat, 32'd34);

        // R10: count 32 fits the 6-bit field of the status readout.
        readout(2'b10, 1'b0, 1'b1, 1'b0, 16'h4020, 16'h0000, 6'd32, "R10 status with count 32");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule